// File: doc/BRIEF.md
# One-Time-Programmable Fuse Register Front End

This block is the register window through which software reaches a one-time-programmable fuse array. It is a behavioural model. The fuse contents are fixed: every word is all ones except two words that carry a serial number and its bitwise complement. Around that array sit fifteen 32-bit control registers on a simple synchronous register bus, all within a 0x1000-byte window. Software points an index register at a fuse word and opens three enable bits: chip enable, data strobe and trim. It then reads the word through a read-only data-out register. If any of the three bits is clear, the data-out register returns the placeholder value 0x000000FF.

All other control registers are plain 32-bit storage that reads back what was written. The fuse index register is the exception: it keeps only its low 12 bits. An access to an offset that is misaligned or lies past the last register is refused. The refusal raises a one-cycle error flag, and a refused read returns zero. Read data is registered.

A small bus state machine tracks what the previous cycle did. It has three states. BUS_IDLE means no read was accepted. BUS_READ_DONE means the read data register was loaded from a mapped register. BUS_FAULT means the previous access was refused. From any state the machine moves as follows: to BUS_FAULT on an access to an unmapped offset; otherwise to BUS_READ_DONE on a read; otherwise to BUS_IDLE.

Top module: `fuse_regfront`

## Requirements
- R1: While reset is high and in the cycle after it, read data is 0 and the error flag is low. Every control register reads 0 after reset.
- R2: Read data changes only in the clock after a read is sampled, and holds its value in cycles with no read.
- R3: The registers at byte offsets 0x04, 0x08, 0x0C, 0x10, 0x14, 0x1C, 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 and 0x38 each store all 32 written bits and read them back unchanged.
- R4: The fuse index register at offset 0x00 keeps only bits 11:0 of a write and reads back with bits 31:12 zero.
- R5: When bit 0 of chip enable (0x0C), bit 0 of data strobe (0x1C) and bit 0 of trim (0x34) are all 1, a read of data out (0x18) returns the fuse word selected by the index register. Unprogrammed words are 0xFFFFFFFF.
- R6: When any one of those three bits 0 is 0, data out reads 0x000000FF. Only bit 0 of each enable register counts.
- R7: Fuse word 0xFC holds the SERIAL parameter and word 0xFD holds its bitwise complement.
- R8: A write to data out (0x18) changes neither its read value nor any other register.
- R9: An access whose offset has bits 1:0 non-zero or is above 0x38 raises the error flag in the next cycle only. Such a read returns 0, and such a write changes no register.
- R10: When a read and a write hit the same register in one cycle, the read returns the value from before the write, and the write takes effect.
- R11: Fuse index values at or beyond the fuse depth read 0xFFFFFFFF.
- R12: A reset in the middle of operation clears all control registers again and leaves the serial words intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte offset inside the register window |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the read |
| bus_err | output | 1 | One-cycle flag for a refused access |

## Verification
The bench builds the block with a fuse depth of 256 words and a serial value of 0xA5C31E77. With that depth the serial pair at words 0xFC and 0xFD is present. The 12-bit index can also reach words 0x100 to 0xFFF, which lie beyond the array, so the all-ones rule for out-of-range words is exercised next to the serial pair. The chosen serial value has mixed bits in every byte, so a swapped or uncomplemented serial word, or one that leaks into a neighbouring index, shows up in a single read.

// File: rtl/fuse_regfront_pkg.sv
package fuse_regfront_pkg;

    // Register slot numbers: byte offset = slot * 4
    localparam int SLOT_W        = 4;
    localparam int NUM_SLOTS     = 15;
    localparam int SLOT_ADDR     = 0;
    localparam int SLOT_ADDR_IO  = 1;
    localparam int SLOT_ADDR_STB = 2;
    localparam int SLOT_CHIP_EN  = 3;
    localparam int SLOT_CLK      = 4;
    localparam int SLOT_DIN      = 5;
    localparam int SLOT_DOUT     = 6;
    localparam int SLOT_DATA_STB = 7;
    localparam int SLOT_PROG     = 8;
    localparam int SLOT_TEST_CTL = 9;
    localparam int SLOT_TEST_MOD = 10;
    localparam int SLOT_TEST_REP = 11;
    localparam int SLOT_TEST_RD  = 12;
    localparam int SLOT_TRIM     = 13;
    localparam int SLOT_WR_EN    = 14;

    localparam int SERIAL_WORD   = 'hFC;

    typedef enum logic [1:0] {
        BUS_IDLE      = 2'd0,
        BUS_READ_DONE = 2'd1,
        BUS_FAULT     = 2'd2
    } bus_state_e;

endpackage

// File: rtl/fuse_access_decode.sv
module fuse_access_decode #(
    parameter int ADDR_W    = 12,
    parameter int SLOT_W    = 4,
    parameter int NUM_SLOTS = 15
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [SLOT_W-1:0] slot
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] WORD_LIMIT = WORD_W'(NUM_SLOTS);

    logic [WORD_W-1:0] word_idx;

    assign word_idx = addr[ADDR_W-1:2];
    assign slot     = addr[SLOT_W+1:2];

    always_comb begin
        hit = (addr[1:0] == 2'b00) && (word_idx < WORD_LIMIT);
    end
endmodule

// File: rtl/fuse_reg_bank.sv
module fuse_reg_bank #(
    parameter int DATA_W      = 32,
    parameter int SLOT_W      = 4,
    parameter int NUM_SLOTS   = 15,
    parameter int INDEX_W     = 12,
    parameter int INDEX_SLOT  = 0,
    parameter int RDONLY_SLOT = 6
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [SLOT_W-1:0]                slot,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0] bank_q
);
    localparam int PAD_W = DATA_W - INDEX_W;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic sel;
        assign sel = wr_en && (slot == SLOT_W'(g));

        if (g == RDONLY_SLOT) begin : g_rdonly
            assign bank_q[g] = '0;
        end else if (g == INDEX_SLOT) begin : g_index
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank_q[g] <= '0;
                end else if (sel) begin
                    bank_q[g] <= {{PAD_W{1'b0}}, wdata[INDEX_W-1:0]};
                end
            end
        end else begin : g_full
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank_q[g] <= '0;
                end else if (sel) begin
                    bank_q[g] <= wdata;
                end
            end
        end
    end
endmodule

// File: rtl/fuse_lookup.sv
module fuse_lookup #(
    parameter int          DATA_W      = 32,
    parameter int          INDEX_W     = 12,
    parameter int          FUSE_DEPTH  = 256,
    parameter int          SERIAL_WORD = 'hFC,
    parameter logic [31:0] SERIAL      = 32'h0
) (
    input  logic [INDEX_W-1:0] idx,
    output logic [DATA_W-1:0]  word
);
    localparam bit HAS_SERIAL = (SERIAL_WORD + 1) < FUSE_DEPTH;
    localparam logic [INDEX_W-1:0] SER_LO = INDEX_W'(SERIAL_WORD);
    localparam logic [INDEX_W-1:0] SER_HI = INDEX_W'(SERIAL_WORD + 1);
    localparam logic [DATA_W-1:0]  SER_V  = DATA_W'(SERIAL);

    if (HAS_SERIAL) begin : g_serial
        always_comb begin
            word = '1;
            if (idx == SER_LO) begin
                word = SER_V;
            end else if (idx == SER_HI) begin
                word = ~SER_V;
            end
        end
    end else begin : g_blank
        assign word = '1;
    end
endmodule

// File: rtl/fuse_regfront.sv
module fuse_regfront
    import fuse_regfront_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 12,
    parameter int          INDEX_W    = 12,
    parameter int          FUSE_DEPTH = 256,
    parameter logic [31:0] SERIAL     = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);
    localparam logic [DATA_W-1:0] CLOSED_WORD = DATA_W'(32'h0000_00FF);

    logic                             hit;
    logic [SLOT_W-1:0]                slot;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] bank_q;
    logic [DATA_W-1:0]                fuse_word;
    logic [DATA_W-1:0]                dout_word;
    logic [DATA_W-1:0]                read_word;
    logic [INDEX_W-1:0]               index_field;
    logic                             ce_bit, strobe_bit, trim_bit;
    bus_state_e                       state_q, state_d;

    fuse_access_decode #(
        .ADDR_W   (ADDR_W),
        .SLOT_W   (SLOT_W),
        .NUM_SLOTS(NUM_SLOTS)
    ) u_decode (
        .addr(bus_addr),
        .hit (hit),
        .slot(slot)
    );

    fuse_reg_bank #(
        .DATA_W     (DATA_W),
        .SLOT_W     (SLOT_W),
        .NUM_SLOTS  (NUM_SLOTS),
        .INDEX_W    (INDEX_W),
        .INDEX_SLOT (SLOT_ADDR),
        .RDONLY_SLOT(SLOT_DOUT)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr && hit),
        .slot  (slot),
        .wdata (bus_wdata),
        .bank_q(bank_q)
    );

    assign index_field = bank_q[SLOT_ADDR][INDEX_W-1:0];
    assign ce_bit      = bank_q[SLOT_CHIP_EN][0];
    assign strobe_bit  = bank_q[SLOT_DATA_STB][0];
    assign trim_bit    = bank_q[SLOT_TRIM][0];

    fuse_lookup #(
        .DATA_W     (DATA_W),
        .INDEX_W    (INDEX_W),
        .FUSE_DEPTH (FUSE_DEPTH),
        .SERIAL_WORD(SERIAL_WORD),
        .SERIAL     (SERIAL)
    ) u_lookup (
        .idx (index_field),
        .word(fuse_word)
    );

    // Data-out opens only with all three enables set
    assign dout_word = (ce_bit && strobe_bit && trim_bit) ? fuse_word : CLOSED_WORD;

    always_comb begin
        read_word = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot == SLOT_W'(i)) begin
                read_word = (i == SLOT_DOUT) ? dout_word : bank_q[i];
            end
        end
    end

    // Next-state rule, identical from every state
    always_comb begin
        state_d = BUS_IDLE;
        if ((bus_rd || bus_wr) && !hit) begin
            state_d = BUS_FAULT;
        end else if (bus_rd) begin
            state_d = BUS_READ_DONE;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: read data follows the transition being taken
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            unique case (state_d)
                BUS_READ_DONE: bus_rdata <= read_word;
                BUS_FAULT:     if (bus_rd) bus_rdata <= '0;
                BUS_IDLE:      bus_rdata <= bus_rdata;
                default:       bus_rdata <= bus_rdata;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            BUS_FAULT: bus_err = 1'b1;
            default:   bus_err = 1'b0;
        endcase
    end
endmodule

// File: rtl/fuse_regfront_chk.sv
module fuse_regfront_chk #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 12,
    parameter int INDEX_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               bus_rd,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               bus_err,
    input logic [INDEX_W-1:0] index_field,
    input logic               ce_bit,
    input logic               strobe_bit,
    input logic               trim_bit
);
    logic refused;
    assign refused = (bus_rd || bus_wr) &&
                     ((bus_addr[1:0] != 2'b00) || (bus_addr > ADDR_W'(12'h038)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0) && !bus_err);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R4
    index_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == '0) |=> index_field == $past(bus_wdata[INDEX_W-1:0]));

    // R6
    closed_dout_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(12'h018) && !(ce_bit && strobe_bit && trim_bit))
        |=> bus_rdata == DATA_W'(32'h0000_00FF));

    // R9
    refused_flag_chk: assert property (@(posedge clk) disable iff (rst)
        refused |=> bus_err);

    // R9
    accepted_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !refused |=> !bus_err);

    // R9
    refused_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (refused && bus_rd) |=> bus_rdata == '0);
endmodule

bind fuse_regfront fuse_regfront_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .INDEX_W(INDEX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .index_field(index_field),
    .ce_bit     (ce_bit),
    .strobe_bit (strobe_bit),
    .trim_bit   (trim_bit)
);

// File: tb/tb_fuse_regfront.sv
module tb_fuse_regfront;
    localparam int          CLK_PERIOD = 10;
    localparam int          DEPTH      = 256;
    localparam logic [31:0] SER        = 32'hA5C3_1E77;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] a   = '0;
    logic        wr  = 1'b0;
    logic        rd  = 1'b0;
    logic [31:0] wd  = '0;
    logic [31:0] rdata;
    logic        err;

    int    checks   = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    string cur_req  = "R1";

    fuse_regfront #(
        .FUSE_DEPTH(DEPTH),
        .SERIAL    (SER)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (a),
        .bus_wr   (wr),
        .bus_wdata(wd),
        .bus_rd   (rd),
        .bus_rdata(rdata),
        .bus_err  (err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic [31:0] m_reg [15];
    logic [31:0] m_rdata = '0;
    logic        m_err   = 1'b0;

    function automatic logic [31:0] m_fuse(input logic [31:0] idx);
        if (idx >= DEPTH)   return 32'hFFFF_FFFF;
        if (idx == 32'hFC)  return SER;
        if (idx == 32'hFD)  return ~SER;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] m_read(input int s);
        if (s == 6) begin
            if (m_reg[3][0] && m_reg[7][0] && m_reg[13][0]) return m_fuse(m_reg[0]);
            return 32'h0000_00FF;
        end
        return m_reg[s];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 15; i++) m_reg[i] = '0;
            m_rdata = '0;
            m_err   = 1'b0;
        end else begin
            logic bad;
            int   s;
            bad   = (a[1:0] != 2'b00) || (a > 12'h038);
            s     = int'(a[5:2]);
            m_err = (rd || wr) && bad;
            if (rd) m_rdata = bad ? 32'h0 : m_read(s);
            if (wr && !bad) begin
                if (s == 0)      m_reg[0] = wd & 32'h0000_0FFF;
                else if (s != 6) m_reg[s] = wd;
            end
        end
    end

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (rdata !== m_rdata || err !== m_err) begin
                failures++;
                $display("FAIL %s model: rdata=%h err=%b expected rdata=%h err=%b",
                         cur_req, rdata, err, m_rdata, m_err);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic [11:0] ad, input logic w, input logic r, input logic [31:0] d);
        @(negedge clk);
        a = ad; wr = w; rd = r; wd = d;
    endtask

    task automatic idle();
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
    endtask

    task automatic write(input logic [11:0] ad, input logic [31:0] d);
        acc(ad, 1'b1, 1'b0, d);
        idle();
    endtask

    task automatic read_chk(input string req, input logic [11:0] ad, input logic [31:0] exp);
        acc(ad, 1'b0, 1'b1, '0);
        idle();
        chk(req, rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", rdata, 32'h0);
        chk("R1", {31'h0, err}, 32'h0);
        rst = 1'b0;
        for (int i = 0; i < 15; i++) begin
            read_chk("R1", 12'(i * 4), (i == 6) ? 32'h0000_00FF : 32'h0);
        end

        // R3: full-width storage
        cur_req = "R3";
        for (int i = 1; i < 15; i++) begin
            if (i != 6) write(12'(i * 4), 32'hC0DE_0000 ^ (32'h1111_1111 * i));
        end
        for (int i = 1; i < 15; i++) begin
            if (i != 6) read_chk("R3", 12'(i * 4), 32'hC0DE_0000 ^ (32'h1111_1111 * i));
        end

        // R4: index register masked to 12 bits
        cur_req = "R4";
        write(12'h000, 32'hDEAD_BEEF);
        read_chk("R4", 12'h000, 32'h0000_0EEF);

        // R6: each enable alone insufficient, only bit 0 matters
        cur_req = "R6";
        write(12'h00C, 32'h0); write(12'h01C, 32'h0); write(12'h034, 32'h0);
        write(12'h000, 32'h0FC);
        read_chk("R6", 12'h018, 32'h0000_00FF);
        write(12'h00C, 32'h1);
        read_chk("R6", 12'h018, 32'h0000_00FF);
        write(12'h01C, 32'h1);
        read_chk("R6", 12'h018, 32'h0000_00FF);
        write(12'h034, 32'hFFFF_FFFE);
        read_chk("R6", 12'h018, 32'h0000_00FF);
        write(12'h034, 32'h1);
        write(12'h00C, 32'hFFFF_FFFE);
        read_chk("R6", 12'h018, 32'h0000_00FF);

        // R7: serial pair, enables with extra bits
        cur_req = "R7";
        write(12'h00C, 32'h8000_0001);
        read_chk("R7", 12'h018, SER);
        write(12'h000, 32'h0FD);
        read_chk("R7", 12'h018, ~SER);

        // R5: ordinary words are unprogrammed
        cur_req = "R5";
        write(12'h000, 32'h010);
        read_chk("R5", 12'h018, 32'hFFFF_FFFF);
        write(12'h000, 32'h0FB);
        read_chk("R5", 12'h018, 32'hFFFF_FFFF);

        // R11: beyond the depth, including an alias of the serial index
        cur_req = "R11";
        write(12'h000, 32'h1FC);
        read_chk("R11", 12'h018, 32'hFFFF_FFFF);
        write(12'h000, 32'hFFF);
        read_chk("R11", 12'h018, 32'hFFFF_FFFF);

        // R8: data-out write ignored
        cur_req = "R8";
        write(12'h000, 32'h0FC);
        write(12'h018, 32'h1234_5678);
        read_chk("R8", 12'h018, SER);
        read_chk("R8", 12'h000, 32'h0000_00FC);
        read_chk("R8", 12'h014, 32'hC0DE_0000 ^ (32'h1111_1111 * 5));

        // R9: refused accesses
        cur_req = "R9";
        acc(12'h03C, 1'b0, 1'b1, '0);
        idle();
        chk("R9", rdata, 32'h0);
        chk("R9", {31'h0, err}, 32'h1);
        @(negedge clk);
        chk("R9", {31'h0, err}, 32'h0);
        acc(12'hFFC, 1'b0, 1'b1, '0);
        idle();
        chk("R9", rdata, 32'h0);
        acc(12'h002, 1'b1, 1'b0, 32'h0000_0ABC);
        idle();
        chk("R9", {31'h0, err}, 32'h1);
        read_chk("R9", 12'h000, 32'h0000_00FC);
        write(12'h03D, 32'hFFFF_FFFF);
        read_chk("R9", 12'h038, 32'hC0DE_0000 ^ (32'h1111_1111 * 14));

        // R10: read and write in the same cycle
        cur_req = "R10";
        acc(12'h014, 1'b1, 1'b1, 32'h5A5A_0F0F);
        idle();
        chk("R10", rdata, 32'hC0DE_0000 ^ (32'h1111_1111 * 5));
        read_chk("R10", 12'h014, 32'h5A5A_0F0F);

        // R2: read data holds while idle, even across writes
        cur_req = "R2";
        write(12'h020, 32'h0BAD_F00D);
        repeat (3) @(negedge clk);
        chk("R2", rdata, 32'h5A5A_0F0F);

        // R12: reset mid-run
        cur_req = "R12";
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_chk("R12", 12'h00C, 32'h0);
        read_chk("R12", 12'h018, 32'h0000_00FF);
        write(12'h00C, 32'h1); write(12'h01C, 32'h1); write(12'h034, 32'h1);
        write(12'h000, 32'h0FD);
        read_chk("R12", 12'h018, ~SER);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule